// File: doc/BRIEF.md
# SECDED-protected SRAM controller with secure upper region

This controller sits between one bus master and an on-chip SRAM array. Each 32-bit word goes into the array as a 39-bit codeword that can correct one flipped bit and detect two. When a read finds a correctable error, the controller repairs the data and raises a sticky flag. When it finds an uncorrectable error, it returns the raw data field, signals a bus error and raises a second sticky flag. A programmable wait state of zero or one cycle can lengthen reads.

A page-aligned threshold splits the RAM. When the secure restriction is on, a non-secure access whose byte offset is at or above the threshold is rejected. A rejected access leaves the RAM unchanged, returns zero and reports an error in the cycle the response would normally appear. Five configuration registers hold the settings and the flags.

The sequencer has three states. ST_IDLE accepts a request. ST_WAIT holds an extra cycle for reads when one wait state is programmed. ST_RESP presents the response for one cycle. The transitions are:
- ST_IDLE goes to ST_RESP on an accepted write, or on a read with zero wait states.
- ST_IDLE goes to ST_WAIT on an accepted read with one wait state.
- ST_WAIT goes to ST_RESP unconditionally.
- ST_RESP returns to ST_IDLE unconditionally.

Top module: `ecc_ram_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `done` is 0. The wait-state, secure-base, secure-enable and both event registers read back as 0.
- R2: A request is accepted when `req` is high while `ready` is high. With zero wait states, `done` is high for exactly one cycle, one cycle after acceptance. A read returns the data last written to that word, and `err` is 0.
- R3: The wait-state register (config address 0) takes a write only when the value is 0 or 1; other values leave it unchanged. With a setting of 1, read responses arrive two cycles after acceptance, while write responses still arrive after one cycle.
- R4: Codewords are laid out as follows: bit 0 is overall parity, bits 1, 2, 4, 8, 16 and 32 are Hamming check bits, and data bits 0..31 fill the remaining positions 3, 5, 6, 7, 9, and so on in ascending order. A read of a codeword with one flipped bit, including bit 0, returns the corrected data with `err` 0. It also sets the fixable flag (config address 3, bit 0).
- R5: A read of a codeword with two flipped bits returns the uncorrected data field with `err` 1. It also sets the non-fixable flag (config address 4, bit 0).
- R6: Both event flags stay set until a config write of exactly zero to their own address. A nonzero write leaves them unchanged.
- R7: The secure-base register (config address 1) reads back the written value with bits [11:0] forced to zero. Bits at or above the RAM's byte-address width are also forced to zero; with the defaults, only bit 12 is kept.
- R8: While the enable bit is set, a non-secure access (`req_nonsec`=1) at a byte offset at or above the base is blocked. A blocked write leaves RAM unchanged. A blocked read returns `rdata`=0. Either kind gives `err`=1 at the normal response cycle.
- R9: Secure accesses, non-secure accesses below the base, and any access while the restriction is disabled reach the RAM normally.
- R10: The secure-enable register (config address 2) stores only bit 0 of the written value and reads back 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken while ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_nonsec | input | 1 | 1 = non-secure master access |
| req_addr | input | WORD_AW+2 | Byte offset into RAM |
| req_wdata | input | 32 | Write data |
| ready | output | 1 | Controller idle and able to accept |
| done | output | 1 | One-cycle response strobe |
| rdata | output | 32 | Read data, valid with done |
| err | output | 1 | Bus error, valid with done |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 3 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for cfg_addr |

## Verification
The assertions run on every cycle. They check:
- `done` lasts a single cycle and never coincides with `ready`.
- A blocked response always carries zero data and an error.
- A decoded single error gives no bus error and sets the fixable flag.
- A double error gives a bus error and sets the non-fixable flag.
- The flags hold until a zero write.
- Base readback never shows low bits.

Only the bench scenarios can show the rest:
- The end-to-end data values.
- The exact response latency under each wait-state setting.
- That a rejected write really left the RAM untouched.
- The correction of deliberately flipped codeword bits.
- The boundary behaviour just below and at the secure base.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

    localparam int DATA_W  = 32;
    localparam int CODE_W  = 39;
    localparam int SYN_W   = 6;
    localparam int PAGE_LSB = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    function automatic logic is_check_pos(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Pull the data field out of a codeword without any correction.
    function automatic logic [DATA_W-1:0] code_data(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [CODE_W-1:0] code_build(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int i = 0; i < SYN_W; i++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if ((p & (1 << i)) != 0) x = x ^ c[p];
            end
            c[1 << i] = x;
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

endpackage

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_ram_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data,
    output logic              err_single,
    output logic              err_double
);

    logic [SYN_W-1:0]  syn;
    logic              parity_odd;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (code[p]) syn = syn ^ SYN_W'(p);
        end
        parity_odd = ^code;
        err_single = parity_odd && (int'(syn) < CODE_W);
        err_double = (!parity_odd && syn != '0) || (parity_odd && int'(syn) >= CODE_W);
        fixed = code;
        for (int p = 1; p < CODE_W; p++) begin
            if (err_single && int'(syn) == p) fixed[p] = ~code[p];
        end
        data = err_double ? code_data(code) : code_data(fixed);
    end

endmodule

// File: rtl/ecc_ram_array.sv
module ecc_ram_array #(
    parameter int WORD_AW = 11,
    parameter int WIDTH   = 39
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [WORD_AW-1:0] word_addr,
    input  logic [WIDTH-1:0]   wr_code,
    output logic [WIDTH-1:0]   rd_code
);

    localparam int DEPTH = 1 << WORD_AW;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[word_addr] <= wr_code;
        if (rd_en) rd_code <= mem[word_addr];
    end

endmodule

// File: rtl/ecc_ram_regs.sv
module ecc_ram_regs
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_BITS = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [2:0]                  cfg_addr,
    input  logic [31:0]                 cfg_wdata,
    output logic [31:0]                 cfg_rdata,
    input  logic                        set_fix,
    input  logic                        set_nonfix,
    output logic                        ws_q,
    output logic                        sec_en_q,
    output logic [ADDR_BITS-1:PAGE_LSB] base_q,
    output logic                        evt_fix_q,
    output logic                        evt_nonfix_q
);

    localparam logic [2:0] A_WAIT   = 3'd0;
    localparam logic [2:0] A_BASE   = 3'd1;
    localparam logic [2:0] A_ENABLE = 3'd2;
    localparam logic [2:0] A_FIX    = 3'd3;
    localparam logic [2:0] A_NONFIX = 3'd4;

    logic wr_zero;
    assign wr_zero = (cfg_wdata == 32'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q         <= 1'b0;
            sec_en_q     <= 1'b0;
            base_q       <= '0;
            evt_fix_q    <= 1'b0;
            evt_nonfix_q <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == A_WAIT && cfg_wdata <= 32'd1) ws_q <= cfg_wdata[0];
            if (cfg_we && cfg_addr == A_ENABLE) sec_en_q <= cfg_wdata[0];
            if (cfg_we && cfg_addr == A_BASE) base_q <= cfg_wdata[ADDR_BITS-1:PAGE_LSB];
            if (set_fix) evt_fix_q <= 1'b1;
            else if (cfg_we && cfg_addr == A_FIX && wr_zero) evt_fix_q <= 1'b0;
            if (set_nonfix) evt_nonfix_q <= 1'b1;
            else if (cfg_we && cfg_addr == A_NONFIX && wr_zero) evt_nonfix_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            A_WAIT:   cfg_rdata[0] = ws_q;
            A_BASE:   cfg_rdata[ADDR_BITS-1:PAGE_LSB] = base_q;
            A_ENABLE: cfg_rdata[0] = sec_en_q;
            A_FIX:    cfg_rdata[0] = evt_fix_q;
            A_NONFIX: cfg_rdata[0] = evt_nonfix_q;
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_ram_ctrl.sv
module ecc_ram_ctrl
    import ecc_ram_pkg::*;
#(
    parameter int WORD_AW = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 req_we,
    input  logic                 req_nonsec,
    input  logic [WORD_AW+1:0]   req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 ready,
    output logic                 done,
    output logic [31:0]          rdata,
    output logic                 err,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata
);

    localparam int ADDR_BITS = WORD_AW + 2;

    seq_state_e state_q, state_d;

    logic                        ws_q, sec_en_q, evt_fix_q, evt_nonfix_q;
    logic [ADDR_BITS-1:PAGE_LSB] base_q;
    logic                        accept, block_now;
    logic                        op_we_q, op_block_q;
    logic                        mem_we, mem_re;
    logic [CODE_W-1:0]           rd_code;
    logic [DATA_W-1:0]           dec_data;
    logic                        dec_single, dec_double;
    logic                        set_fix, set_nonfix;
    logic [ADDR_BITS-1:0]        base_full;

    assign base_full = {base_q, {PAGE_LSB{1'b0}}};
    assign accept    = req && (state_q == ST_IDLE);
    assign block_now = sec_en_q && req_nonsec && (req_addr >= base_full);
    assign mem_we    = accept && req_we && !block_now;
    assign mem_re    = accept && !req_we && !block_now;

    ecc_ram_regs #(.ADDR_BITS(ADDR_BITS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .set_fix      (set_fix),
        .set_nonfix   (set_nonfix),
        .ws_q         (ws_q),
        .sec_en_q     (sec_en_q),
        .base_q       (base_q),
        .evt_fix_q    (evt_fix_q),
        .evt_nonfix_q (evt_nonfix_q)
    );

    ecc_ram_array #(.WORD_AW(WORD_AW), .WIDTH(CODE_W)) u_array (
        .clk       (clk),
        .wr_en     (mem_we),
        .rd_en     (mem_re),
        .word_addr (req_addr[ADDR_BITS-1:2]),
        .wr_code   (code_build(req_wdata)),
        .rd_code   (rd_code)
    );

    ecc_secded_dec u_dec (
        .code       (rd_code),
        .data       (dec_data),
        .err_single (dec_single),
        .err_double (dec_double)
    );

    // State register and captured request attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_we_q    <= 1'b0;
            op_block_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_we_q    <= req_we;
                op_block_q <= block_now;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (req_we || !ws_q) ? ST_RESP : ST_WAIT;
            ST_WAIT: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready      = 1'b0;
        done       = 1'b0;
        rdata      = '0;
        err        = 1'b0;
        set_fix    = 1'b0;
        set_nonfix = 1'b0;
        unique case (state_q)
            ST_IDLE: ready = 1'b1;
            ST_WAIT: ready = 1'b0;
            ST_RESP: begin
                done = 1'b1;
                if (op_block_q) begin
                    err = 1'b1;
                end else if (!op_we_q) begin
                    rdata      = dec_data;
                    err        = dec_double;
                    set_fix    = dec_single;
                    set_nonfix = dec_double;
                end
            end
            default: ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/ecc_ram_ctrl_chk.sv
module ecc_ram_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ready,
    input logic        done,
    input logic        err,
    input logic [31:0] rdata,
    input logic        op_we,
    input logic        op_block,
    input logic        dec_single,
    input logic        dec_double,
    input logic        evt_fix,
    input logic        evt_nonfix,
    input logic        cfg_we,
    input logic [2:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata
);

    logic rd_ok;
    assign rd_ok = done && !op_we && !op_block;

    // R2: single-cycle response strobe
    a_r2_one_beat: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R2: no response while idle
    a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n) ready |-> !done);
    // R8: blocked accesses answer zero with error
    a_r8_block_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_block) |-> (err && rdata == 32'd0));
    // R4: corrected read has no bus error and raises the fixable flag
    a_r4_fix_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && dec_single) |-> !err);
    a_r4_fix_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && dec_single) |=> evt_fix);
    // R5: uncorrectable read errors and raises the non-fixable flag
    a_r5_nonfix_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && dec_double) |-> err);
    a_r5_nonfix_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && dec_double) |=> evt_nonfix);
    // R6: flags hold until a zero write to their own address
    a_r6_fix_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_fix && !(cfg_we && cfg_addr == 3'd3 && cfg_wdata == 32'd0)) |=> evt_fix);
    a_r6_nonfix_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_nonfix && !(cfg_we && cfg_addr == 3'd4 && cfg_wdata == 32'd0)) |=> evt_nonfix);
    // R7: base readback never shows page-offset bits
    a_r7_base_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 3'd1) |-> (cfg_rdata[11:0] == 12'd0));

endmodule

bind ecc_ram_ctrl ecc_ram_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .done       (done),
    .err        (err),
    .rdata      (rdata),
    .op_we      (op_we_q),
    .op_block   (op_block_q),
    .dec_single (dec_single),
    .dec_double (dec_double),
    .evt_fix    (evt_fix_q),
    .evt_nonfix (evt_nonfix_q),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/ecc_ram_ctrl_bench.sv
module ecc_ram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_AW    = 11;
    localparam int ADDR_BITS  = WORD_AW + 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req = 1'b0, req_we = 1'b0, req_nonsec = 1'b0;
    logic [ADDR_BITS-1:0] req_addr = '0;
    logic [31:0]          req_wdata = '0;
    logic                 ready, done, err;
    logic [31:0]          rdata;
    logic                 cfg_we = 1'b0;
    logic [2:0]           cfg_addr = '0;
    logic [31:0]          cfg_wdata = '0;
    logic [31:0]          cfg_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Behavioural reference state
    logic [31:0] ref_mem [int];
    int          ref_flip [int];
    int          ref_ws = 0, ref_en = 0, ref_fix = 0, ref_nonfix = 0;
    logic [31:0] ref_base = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_ram_ctrl #(.WORD_AW(WORD_AW)) u_ecc_ram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_nonsec(req_nonsec),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
        .rdata(rdata), .err(err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_cfg(input int a);
        case (a)
            0: return 32'(ref_ws);
            1: return ref_base;
            2: return 32'(ref_en);
            3: return 32'(ref_fix);
            4: return 32'(ref_nonfix);
            default: return 32'd0;
        endcase
    endfunction

    task automatic cfg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
        case (a)
            0: if (d <= 1) ref_ws = int'(d);
            1: ref_base = d & (32'((1 << ADDR_BITS) - 1) & ~32'hFFF);
            2: ref_en = int'(d[0]);
            3: if (d == 0) ref_fix = 0;
            4: if (d == 0) ref_nonfix = 0;
            default: ;
        endcase
    endtask

    task automatic cfg_check(input int a, input string tag);
        @(negedge clk);
        cfg_addr = 3'(a);
        #1;
        check(cfg_rdata == ref_cfg(a), tag, cfg_rdata, ref_cfg(a));
    endtask

    // One bus transaction; expectations come from the reference state.
    task automatic bus(input bit we, input bit ns, input logic [31:0] addr,
                       input logic [31:0] wd, input string tag);
        bit blocked;
        int w, lat;
        logic [31:0] exp_d;
        bit exp_e;
        w = int'(addr >> 2);
        blocked = (ref_en != 0) && ns && (addr >= ref_base);
        lat = (we || ref_ws == 0) ? 1 : 2;
        exp_d = 32'd0;
        exp_e = blocked;
        if (we) begin
            if (!blocked) begin
                ref_mem[w] = wd;
                ref_flip[w] = 0;
            end
        end else if (!blocked) begin
            exp_d = ref_mem[w];
            if (ref_flip[w] == 1) ref_fix = 1;
            if (ref_flip[w] == 2) begin
                exp_d = exp_d ^ 32'd1;
                exp_e = 1'b1;
                ref_nonfix = 1;
            end
        end
        @(negedge clk);
        check(ready == 1'b1, {tag, " ready"}, 32'(ready), 32'd1);
        req = 1'b1; req_we = we; req_nonsec = ns; req_addr = addr[ADDR_BITS-1:0]; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        for (int c = 1; c <= lat; c++) begin
            if (c > 1) @(negedge clk);
            if (c < lat) begin
                check(done == 1'b0, {tag, " early done"}, 32'(done), 32'd0);
            end else begin
                check(done == 1'b1, {tag, " done"}, 32'(done), 32'd1);
                check(err == exp_e, {tag, " err"}, 32'(err), 32'(exp_e));
                check(rdata == exp_d, {tag, " rdata"}, rdata, exp_d);
            end
        end
        @(negedge clk);
        check(done == 1'b0 && ready == 1'b1, {tag, " back to idle"}, 32'({done, ready}), 32'd1);
    endtask

    task automatic inject(input int w, input int ia, input int ib, input int kind);
        @(negedge clk);
        u_ecc_ram_ctrl.u_array.mem[w][ia] = ~u_ecc_ram_ctrl.u_array.mem[w][ia];
        if (ib >= 0) u_ecc_ram_ctrl.u_array.mem[w][ib] = ~u_ecc_ram_ctrl.u_array.mem[w][ib];
        ref_flip[w] = kind;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0, "R1 idle after reset", 32'({ready, done}), 32'd2);
        for (int a = 0; a < 5; a++) cfg_check(a, "R1 reset register");

        // R2 plain write/read patterns
        bus(1, 0, 32'h0000, 32'hDEADBEEF, "R2 wr0");
        bus(1, 0, 32'h0004, 32'h00000000, "R2 wr1");
        bus(1, 0, 32'h1FFC, 32'hFFFFFFFF, "R2 wr top");
        bus(1, 0, 32'h0800, 32'hA5A55A5A, "R2 wr mid");
        bus(0, 0, 32'h0000, 0, "R2 rd0");
        bus(0, 0, 32'h0004, 0, "R2 rd1");
        bus(0, 0, 32'h1FFC, 0, "R2 rd top");
        bus(0, 1, 32'h0800, 0, "R2 rd mid nonsec");

        // R3 wait-state register and latency
        cfg_write(0, 32'd2);
        cfg_check(0, "R3 ws ignores 2");
        cfg_write(0, 32'd1);
        cfg_check(0, "R3 ws one");
        bus(0, 0, 32'h0000, 0, "R3 rd ws1");
        bus(1, 0, 32'h0010, 32'h12345678, "R3 wr ws1");
        bus(0, 0, 32'h0010, 0, "R3 rd back ws1");
        cfg_write(0, 32'd7);
        cfg_check(0, "R3 ws ignores 7");
        cfg_write(0, 32'd0);
        bus(0, 0, 32'h0010, 0, "R3 rd ws0");

        // R4 single-bit errors
        inject(4, 5, -1, 1);
        bus(0, 0, 32'h0010, 0, "R4 data bit corrected");
        cfg_check(3, "R4 fix flag");
        cfg_check(4, "R4 nonfix flag clear");
        bus(1, 0, 32'h0020, 32'hCAFEF00D, "R4 wr");
        inject(8, 0, -1, 1);
        bus(0, 0, 32'h0020, 0, "R4 parity bit corrected");

        // R6 flag stickiness
        cfg_write(3, 32'd1);
        cfg_check(3, "R6 fix stays on nonzero write");
        cfg_write(3, 32'd0);
        cfg_check(3, "R6 fix cleared");

        // R5 double-bit error
        bus(1, 0, 32'h0030, 32'h0F0F0F0E, "R5 wr");
        inject(12, 3, 1, 2);
        bus(0, 0, 32'h0030, 0, "R5 double raw data");
        cfg_check(4, "R5 nonfix flag");
        cfg_check(3, "R5 fix flag untouched");
        cfg_write(4, 32'h80000000);
        cfg_check(4, "R6 nonfix stays on nonzero write");
        cfg_write(4, 32'd0);
        cfg_check(4, "R6 nonfix cleared");

        // R7 base masking
        cfg_write(1, 32'hFFFFFFFF);
        cfg_check(1, "R7 base mask");
        cfg_write(1, 32'h00000FFF);
        cfg_check(1, "R7 base low ignored");
        cfg_write(1, 32'h00001234);
        cfg_check(1, "R7 base page");

        // R10 enable bit
        cfg_write(2, 32'd3);
        cfg_check(2, "R10 enable bit0 only");
        cfg_write(2, 32'd2);
        cfg_check(2, "R10 enable cleared by bit0=0");
        cfg_write(2, 32'd1);

        // R8 / R9 secure boundary at 0x1000
        bus(1, 0, 32'h1004, 32'h11112222, "R9 secure wr above base");
        bus(1, 1, 32'h1004, 32'h99999999, "R8 blocked wr");
        bus(0, 0, 32'h1004, 0, "R8 blocked wr left RAM");
        bus(0, 1, 32'h1004, 0, "R8 blocked rd");
        bus(0, 1, 32'h1000, 0, "R8 blocked rd at base");
        bus(1, 1, 32'h0FFC, 32'h55556666, "R9 nonsec wr below base");
        bus(0, 1, 32'h0FFC, 0, "R9 nonsec rd below base");
        cfg_write(0, 32'd1);
        bus(0, 1, 32'h1FFC, 0, "R8 blocked rd ws1");
        bus(1, 1, 32'h1FFC, 32'h0, "R8 blocked wr ws1");
        cfg_write(0, 32'd0);
        cfg_write(1, 32'd0);
        bus(0, 1, 32'h0000, 0, "R8 base zero blocks all");
        bus(0, 0, 32'h0000, 0, "R9 secure at base zero");
        cfg_write(2, 32'd0);
        bus(1, 1, 32'h1004, 32'h77778888, "R9 disabled nonsec wr");
        bus(0, 1, 32'h1004, 0, "R9 disabled nonsec rd");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule